// File: doc/BRIEF.md
# Prescaled Match-Action Timer

This block is a 16-bit timer whose counter advances once per programmable prescale period. Four compare values are checked against the counter on every cycle. Each compare slot has three enables of its own: one to raise an interrupt flag, one to send the counter back to zero, and one to halt counting. Software reaches every register through a plain synchronous strobe port. Reads are combinational and writes take effect on the clock edge.

Run control is a four-state machine whose state bits are the two control bits {hold, run}. The states are ST_IDLE (00), ST_COUNT (01), ST_HOLD (10) and ST_HOLD_ARMED (11). Any write to the control word moves the machine to the state named by the written bits. In ST_COUNT, a compare hit whose halt enable is set moves the machine to ST_IDLE. This transition has priority over a control write in the same cycle. Both hold states force the prescale counter and the timer counter to zero.

Word address map: 0 interrupt flags (write 1 to clear, bit n for slot n), 1 control (bit 0 run, bit 1 hold), 2 timer counter, 3 prescale limit, 4 prescale counter, 5 action enables, 6 to 9 compare slots 0 to 3. Addresses outside the map read as 0.

Top module: `match_timer`

## Requirements
- R1: After reset every register reads 0 and irq is low.
- R2: While counting, the prescale counter steps by one on each clock. When it has reached the prescale limit, it returns to 0 and the timer counter increments by one. After k counting edges from zero with limit P, the timer counter is k/(P+1) and the prescale counter is k mod (P+1).
- R3: A compare hit on slot n occurs while counting, when the timer counter equals slot n and the prescale counter is 0. If action bit 3n (interrupt) is set, flag bit n is set on the next edge. irq is high exactly when any flag is set.
- R4: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R5: If action bit 3n+1 (zero-on-hit) is set, the increment that would leave the matched value loads 0 instead. The counter therefore holds the matched value for a full prescale period before wrapping.
- R6: If action bit 3n+2 (halt-on-hit) is set, a hit freezes both counters at their values and clears control bit 0 on the next edge.
- R7: Action-enable bits 31:12 always read 0. Writing ones there does not change the stored bits 11:0.
- R8: While control bit 1 is set, both counters are held at 0. Clearing it with bit 0 set starts counting from zero.
- R9: With no action bits set, hits have no effect: the counter wraps from 0xFFFF to 0 and no flag is set.
- R10: With control bit 0 clear, the counters stand still. Bus writes to the timer counter or prescale counter load them directly and take priority over counting.
- R11: When zero-on-hit and halt-on-hit are both set for a hit, halt wins and the counter stays at the matched value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Interrupt request, OR of flags |

## Verification
The assertions assume that addresses stay inside the map. They also assume that the prescale limit is not moved below the prescale counter while counting. A limit written that way would make the step and hold properties describe a counter that runs up to the wrap.

The stimulus changes the limit, the action enables and the compare slots only while the machine is held or idle. It then starts counting with a single control write, so every expected value counts edges from a known zero.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // State encoding equals the control word bits {hold, run}.
    typedef enum logic [1:0] {
        ST_IDLE       = 2'b00,
        ST_COUNT      = 2'b01,
        ST_HOLD       = 2'b10,
        ST_HOLD_ARMED = 2'b11
    } tmr_state_e;

    localparam int A_FLAGS  = 0;
    localparam int A_CTRL   = 1;
    localparam int A_TC     = 2;
    localparam int A_PR     = 3;
    localparam int A_PC     = 4;
    localparam int A_MCTRL  = 5;
    localparam int A_MATCH0 = 6;

    localparam int ACT_BITS = 3;  // interrupt, zero, halt per slot

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          count_en,
    input  logic          hold,
    input  logic          freeze,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    input  logic [TW-1:0] limit,
    output logic [TW-1:0] pc,
    output logic          tick
);

    assign tick = count_en && !freeze && (pc >= limit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (hold) begin
            pc <= '0;
        end else if (load) begin
            pc <= load_val;
        end else if (count_en && !freeze) begin
            pc <= tick ? '0 : pc + TW'(1);
        end
    end

endmodule

// File: rtl/tmr_match_bank.sv
module tmr_match_bank #(
    parameter int TW     = 16,
    parameter int NMATCH = 4
) (
    input  logic                 running,
    input  logic                 pc_zero,
    input  logic [TW-1:0]        tc,
    input  logic [NMATCH*TW-1:0] slots,
    output logic [NMATCH-1:0]    eq,
    output logic [NMATCH-1:0]    hit
);

    for (genvar g = 0; g < NMATCH; g++) begin : g_cmp
        assign eq[g]  = (tc == slots[g*TW +: TW]);
        assign hit[g] = eq[g] && running && pc_zero;
    end

endmodule

// File: rtl/tmr_ctrl_fsm.sv
module tmr_ctrl_fsm
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [1:0] ctrl_wdata,
    input  logic       halt_hit,
    output logic       running,
    output logic       holding,
    output logic [1:0] ctrl_rd
);

    tmr_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (ctrl_wr) state_nx = tmr_state_e'(ctrl_wdata);
            end
            ST_COUNT: begin
                if (halt_hit)     state_nx = ST_IDLE;
                else if (ctrl_wr) state_nx = tmr_state_e'(ctrl_wdata);
            end
            ST_HOLD: begin
                if (ctrl_wr) state_nx = tmr_state_e'(ctrl_wdata);
            end
            ST_HOLD_ARMED: begin
                if (ctrl_wr) state_nx = tmr_state_e'(ctrl_wdata);
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        running = 1'b0;
        holding = 1'b0;
        unique case (state)
            ST_IDLE:       ;
            ST_COUNT:      running = 1'b1;
            ST_HOLD:       holding = 1'b1;
            ST_HOLD_ARMED: holding = 1'b1;
            default:       ;
        endcase
        ctrl_rd = state;
    end

endmodule

// File: rtl/match_timer.sv
module match_timer
    import tmr_pkg::*;
#(
    parameter int TW     = 16,
    parameter int NMATCH = 4,
    parameter int DW     = 32,
    parameter int AW     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);

    localparam int MCW = ACT_BITS * NMATCH;

    logic [TW-1:0]        tc, pr, pc;
    logic [MCW-1:0]       mctrl;
    logic [TW-1:0]        mr [NMATCH];
    logic [NMATCH*TW-1:0] mr_flat;
    logic [NMATCH-1:0]    flags, flag_clr;
    logic [NMATCH-1:0]    eq, hit, int_en, zero_en, halt_en;
    logic                 running, holding, tick, halt_hit, zero_hit;
    logic [1:0]           ctrl_rd;
    logic                 wr_hit;
    logic                 unused_wdata_hi;

    assign wr_hit = bus_sel && bus_wr;
    assign unused_wdata_hi = ^bus_wdata[DW-1:TW];

    for (genvar g = 0; g < NMATCH; g++) begin : g_slot
        assign int_en[g]  = mctrl[ACT_BITS*g];
        assign zero_en[g] = mctrl[ACT_BITS*g+1];
        assign halt_en[g] = mctrl[ACT_BITS*g+2];
        assign mr_flat[g*TW +: TW] = mr[g];
    end

    assign halt_hit = |(hit & halt_en);
    assign zero_hit = |(eq & zero_en);

    tmr_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (wr_hit && bus_addr == AW'(A_CTRL)),
        .ctrl_wdata(bus_wdata[1:0]),
        .halt_hit  (halt_hit),
        .running   (running),
        .holding   (holding),
        .ctrl_rd   (ctrl_rd)
    );

    tmr_prescale #(.TW(TW)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_en(running),
        .hold    (holding),
        .freeze  (halt_hit),
        .load    (wr_hit && bus_addr == AW'(A_PC)),
        .load_val(bus_wdata[TW-1:0]),
        .limit   (pr),
        .pc      (pc),
        .tick    (tick)
    );

    tmr_match_bank #(.TW(TW), .NMATCH(NMATCH)) u_bank (
        .running(running),
        .pc_zero(pc == '0),
        .tc     (tc),
        .slots  (mr_flat),
        .eq     (eq),
        .hit    (hit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc <= '0;
        end else if (holding) begin
            tc <= '0;
        end else if (wr_hit && bus_addr == AW'(A_TC)) begin
            tc <= bus_wdata[TW-1:0];
        end else if (tick) begin
            tc <= zero_hit ? '0 : tc + TW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pr    <= '0;
            mctrl <= '0;
        end else if (wr_hit) begin
            if (bus_addr == AW'(A_PR))    pr    <= bus_wdata[TW-1:0];
            if (bus_addr == AW'(A_MCTRL)) mctrl <= bus_wdata[MCW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        for (int n = 0; n < NMATCH; n++) begin
            if (!rst_n)
                mr[n] <= '0;
            else if (wr_hit && bus_addr == AW'(A_MATCH0 + n))
                mr[n] <= bus_wdata[TW-1:0];
        end
    end

    assign flag_clr = (wr_hit && bus_addr == AW'(A_FLAGS)) ? bus_wdata[NMATCH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~flag_clr) | (hit & int_en);
    end

    assign irq = |flags;

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (bus_addr == AW'(A_FLAGS)) bus_rdata = DW'(flags);
            if (bus_addr == AW'(A_CTRL))  bus_rdata = DW'(ctrl_rd);
            if (bus_addr == AW'(A_TC))    bus_rdata = DW'(tc);
            if (bus_addr == AW'(A_PR))    bus_rdata = DW'(pr);
            if (bus_addr == AW'(A_PC))    bus_rdata = DW'(pc);
            if (bus_addr == AW'(A_MCTRL)) bus_rdata = DW'(mctrl);
            for (int n = 0; n < NMATCH; n++)
                if (bus_addr == AW'(A_MATCH0 + n)) bus_rdata = DW'(mr[n]);
        end
    end

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int TW     = 16,
    parameter int NMATCH = 4,
    parameter int DW     = 32,
    parameter int AW     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [AW-1:0]     bus_addr,
    input logic [DW-1:0]     bus_rdata,
    input logic              irq,
    input logic              running,
    input logic              holding,
    input logic [TW-1:0]     tc,
    input logic [TW-1:0]     pc,
    input logic [TW-1:0]     pr,
    input logic [NMATCH-1:0] eq,
    input logic [NMATCH-1:0] hit,
    input logic [NMATCH-1:0] int_en,
    input logic [NMATCH-1:0] zero_en,
    input logic [NMATCH-1:0] halt_en,
    input logic [NMATCH-1:0] flags
);

    localparam int MCW = ACT_BITS * NMATCH;

    logic cnt_wr, halting;
    assign cnt_wr  = bus_sel && bus_wr && (bus_addr == AW'(A_TC) || bus_addr == AW'(A_PC));
    assign halting = (hit & halt_en) != '0;

    AST_TC_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (running && pc < pr && !halting && !cnt_wr) |=> $stable(tc)); // R2

    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit & int_en) != '0) |=> ((flags & $past(hit & int_en)) == $past(hit & int_en))); // R3

    AST_IRQ_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && (hit & int_en) == '0) |=> !irq); // R3

    AST_ZERO_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (running && pc >= pr && (eq & zero_en) != '0 && !halting && !cnt_wr) |=> (tc == '0)); // R5

    AST_HALT_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        halting |=> !running); // R6

    AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (halting && !cnt_wr) |=> ($stable(tc) && $stable(pc))); // R6

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == AW'(A_MCTRL)) |-> (bus_rdata[DW-1:MCW] == '0)); // R7

    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        holding |=> (tc == '0 && pc == '0)); // R8

    AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !holding && !cnt_wr) |=> ($stable(tc) && $stable(pc))); // R10

endmodule

bind match_timer tmr_checker #(.TW(TW), .NMATCH(NMATCH), .DW(DW), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .irq      (irq),
    .running  (running),
    .holding  (holding),
    .tc       (tc),
    .pc       (pc),
    .pr       (pr),
    .eq       (eq),
    .hit      (hit),
    .int_en   (int_en),
    .zero_en  (zero_en),
    .halt_en  (halt_en),
    .flags    (flags)
);

// File: tb/sim_match_timer.sv
`timescale 1ns/1ps
module sim_match_timer;
    import tmr_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    match_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // {prescale limit, counting edges, expected counter, expected prescale count}
    localparam logic [15:0] VEC [0:6][0:3] = '{
        '{16'd0, 16'd5,  16'd5, 16'd0},
        '{16'd1, 16'd5,  16'd2, 16'd1},
        '{16'd3, 16'd9,  16'd2, 16'd1},
        '{16'd4, 16'd10, 16'd2, 16'd0},
        '{16'd7, 16'd20, 16'd2, 16'd4},
        '{16'd9, 16'd33, 16'd3, 16'd3},
        '{16'd2, 16'd0,  16'd0, 16'd0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'(addr); bus_wdata = data;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'(addr);
        #1;
        data = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic prep(input logic [15:0] lim, input logic [31:0] act);
        wr(A_CTRL, 32'h2);
        wr(A_FLAGS, 32'hF);
        wr(A_MCTRL, act);
        wr(A_PR, 32'(lim));
        wr(A_CTRL, 32'h1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_TC, v);     chk("R1 tc", v, 0);
        rd(A_PC, v);     chk("R1 pc", v, 0);
        rd(A_CTRL, v);   chk("R1 ctrl", v, 0);
        rd(A_FLAGS, v);  chk("R1 flags", v, 0);
        rd(A_MCTRL, v);  chk("R1 mctrl", v, 0);
        rd(A_MATCH0, v); chk("R1 slot0", v, 0);
        chk("R1 irq", 32'(irq), 0);

        // R2 prescale table
        for (int i = 0; i < 7; i++) begin
            prep(VEC[i][0], 32'h0);
            edges(int'(VEC[i][1]));
            rd(A_TC, v); chk("R2 tc", v, 32'(VEC[i][2]));
            rd(A_PC, v); chk("R2 pc", v, 32'(VEC[i][3]));
        end

        // R3 interrupt on slot 1 (bit 3)
        wr(A_MATCH0 + 1, 32'd3);
        prep(16'd0, 32'h8);
        edges(3);
        chk("R3 irq before", 32'(irq), 0);
        edges(1);
        rd(A_FLAGS, v); chk("R3 flags", v, 32'h2);
        chk("R3 irq after", 32'(irq), 1);

        // R4 write-one-to-clear
        wr(A_FLAGS, 32'h0);
        rd(A_FLAGS, v); chk("R4 zero write", v, 32'h2);
        wr(A_FLAGS, 32'h2);
        rd(A_FLAGS, v); chk("R4 cleared", v, 0);
        chk("R4 irq", 32'(irq), 0);

        // R5 zero-on-hit slot 0 (bit 1), limit 2
        wr(A_MATCH0, 32'd4);
        prep(16'd2, 32'h2);
        edges(14);
        rd(A_TC, v); chk("R5 hold value", v, 4);
        rd(A_PC, v); chk("R5 pc", v, 2);
        edges(1);
        rd(A_TC, v); chk("R5 wrapped", v, 0);
        edges(3);
        rd(A_TC, v); chk("R5 resumes", v, 1);
        rd(A_FLAGS, v); chk("R5 no flag", v, 0);

        // R6 halt-on-hit slot 2 (bits 8 and 6), limit 1
        wr(A_MATCH0 + 2, 32'd5);
        prep(16'd1, 32'h140);
        edges(11);
        rd(A_TC, v);    chk("R6 tc", v, 5);
        rd(A_PC, v);    chk("R6 pc", v, 0);
        rd(A_CTRL, v);  chk("R6 run cleared", v, 0);
        rd(A_FLAGS, v); chk("R6 flag", v, 32'h4);
        edges(9);
        rd(A_TC, v);    chk("R6 still", v, 5);

        // R11 halt beats zero on slot 0
        wr(A_MATCH0, 32'd2);
        prep(16'd0, 32'h6);
        edges(5);
        rd(A_TC, v);   chk("R11 tc", v, 2);
        rd(A_CTRL, v); chk("R11 ctrl", v, 0);

        // R7 reserved bits
        wr(A_MCTRL, 32'hFFFF_F005);
        rd(A_MCTRL, v); chk("R7 readback", v, 32'h005);
        wr(A_MCTRL, 32'h0);

        // R8 hold
        wr(A_PR, 32'h0);
        wr(A_CTRL, 32'h3);
        edges(10);
        rd(A_TC, v);   chk("R8 tc held", v, 0);
        rd(A_PC, v);   chk("R8 pc held", v, 0);
        rd(A_CTRL, v); chk("R8 ctrl", v, 3);
        wr(A_CTRL, 32'h1);
        edges(4);
        rd(A_TC, v);   chk("R8 released", v, 4);

        // R10 stop and direct loads
        wr(A_CTRL, 32'h0);
        edges(5);
        rd(A_TC, v);   chk("R10 stopped", v, 5);
        wr(A_TC, 32'h1234);
        edges(3);
        rd(A_TC, v);   chk("R10 tc load", v, 32'h1234);
        wr(A_PR, 32'd5);
        wr(A_PC, 32'd3);
        rd(A_PC, v);   chk("R10 pc load", v, 3);
        wr(A_CTRL, 32'h1);
        edges(3);
        rd(A_TC, v);   chk("R10 tc tick", v, 32'h1235);
        rd(A_PC, v);   chk("R10 pc wrap", v, 0);

        // R9 full-scale wrap with no actions
        wr(A_MATCH0 + 3, 32'hFFFF);
        wr(A_MATCH0, 32'h0);
        prep(16'd0, 32'h0);
        wr(A_TC, 32'hFFFD);
        edges(3);
        rd(A_TC, v);    chk("R9 wrap", v, 0);
        rd(A_FLAGS, v); chk("R9 no flags", v, 0);
        chk("R9 irq", 32'(irq), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule